// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two independent timer/counter channels. Each channel keeps its count in a low byte and a high byte. Both bytes can be read and written over a small register bus. A shared 8-bit mode register sets up both channels. A channel counts either machine-cycle strobes or falling edges on its own count pin. It runs when its run bit is set. When its gate field is set, it also needs its gate pin to be high.

Four geometries are available:
- **13-bit:** five low bits of the low byte act as a prescaler below an 8-bit high byte.
- **16-bit:** a full 16-bit count.
- **8-bit auto-reload:** the low byte counts and refills itself from the high byte.
- **Split:** channel 0 becomes two 8-bit counters, and the upper one uses channel 1's run bit and flag.

Each overflow sets a sticky flag, which also drives an output pin. Software clears a flag by writing a one to it, and an acknowledge pin also clears it.

Named states and transitions:
- **Edge detector, per channel:** two states, `ES_LOW` and `ES_HIGH`, advancing only on the machine-cycle strobe. `ES_LOW -> ES_HIGH` when the synchronised pin sample is 1. `ES_HIGH -> ES_LOW` when the sample is 0, and that transition fires one count event.
- **Count core, per channel:** the mode field selects one of four count behaviours: `MD_13`, `MD_16`, `MD_RELOAD` and `MD_SPLIT`. Changing the mode takes effect at the next strobe and does not alter the stored bytes.

Top module: `tmr_dual`

## Requirements
- R1: After reset, all four count bytes, the mode register, both run bits and both flags read as zero, and `irq_flag` is 0.
- R2: Register map and fields:
  - Bus addresses: 0 is the ch0 low byte, 1 the ch0 high byte, 2 the ch1 low byte, 3 the ch1 high byte, 4 the mode register and 5 the control register. Addresses 6 and 7 read as zero.
  - Mode register: ch0 uses bits [3:0] and ch1 uses bits [7:4]. Within a nibble, bit 3 is gate, bit 2 selects external counting, and bits [1:0] are the mode (00 = 13-bit, 01 = 16-bit, 10 = auto-reload, 11 = split).
  - Control register: bit 0 is run0 and bit 1 is run1; a write loads both. Bit 4 is flag0 and bit 5 is flag1; writing 1 to a flag bit clears it and writing 0 leaves it unchanged.
- R3: Mode 00 behaves as follows:
  - Low bits [4:0] count 0..31, and wrapping 31 to 0 increments the high byte.
  - Low bits [7:5] never change by counting.
  - The flag is set when the count wraps from 8191 to 0.
- R4: Mode 01 counts {high, low} from 0 to 65535. It wraps to 0 and sets the flag on that wrap.
- R5: Mode 10 counts the low byte. On an increment at 255, the low byte is loaded from the high byte and the flag is set. The high byte does not change.
- R6: With ch0 in mode 11:
  - The ch0 low byte counts as an 8-bit counter under ch0's controls and sets flag0 when it wraps from 255 to 0.
  - The ch0 high byte counts every machine cycle while run1 is 1 and sets flag1 when it wraps from 255 to 0.
- R7: With ch0 in mode 11, ch1 (in mode 00, 01 or 10) advances on every strobe regardless of run1, gate or source select, and it never sets a flag. Ch1 in mode 11 holds its count.
- R8: In external mode, a count occurs on the second strobe that samples the count pin low, after a strobe that sampled it high. Strobes without such an edge do not count.
- R9: With gate set, the channel counts only on strobes for which the gate pin was sampled high at the previous strobe. The pin is sampled once per strobe.
- R10: A bus write to a count byte on the same clock as an increment stores the written value. In modes 00, 01 and 10, that increment and its overflow are discarded.
- R11: A flag stays set until a write-one-to-clear or an `intack` pulse clears it. If a set and a clear land on the same clock, the set wins.
- R12: Counts change only on clocks where `mc_tick` is 1 and the channel is enabled; with its run bit 0, a channel holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | External gate inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| intack | input | 2 | Per-channel flag acknowledge (clear) |
| irq_flag | output | 2 | Overflow flags |

## Verification
Latencies the checks rely on:
- Count bytes and flags change on the clock edge that samples `mc_tick` high, so the bench samples them at the falling edge right after that strobe.
- Register writes are visible at the falling edge after the write clock.
- A gate change takes effect one strobe later.
- An external falling edge shows up on the second strobe after the pin drops.

The bench asserts the "not yet" value before the edge and the new value after it. Each model step matches one strobe issued while the channel is enabled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MD_13     = 2'b00,
        MD_16     = 2'b01,
        MD_RELOAD = 2'b10,
        MD_SPLIT  = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext;
        tmr_mode_e mode;
    } chan_cfg_t;

    localparam int unsigned ADDR_W       = 3;
    localparam int unsigned CFG_W        = 4;
    localparam int unsigned NCH          = 2;
    localparam int unsigned CTL_FLAG_LSB = 4;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd5;
endpackage

// File: rtl/tmr_edge_fsm.sv
module tmr_edge_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    typedef enum logic {ES_LOW, ES_HIGH} edge_state_e;

    edge_state_e state_q, state_nx;
    logic        pin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ES_LOW;
            pin_q   <= 1'b0;
        end else if (tick) begin
            state_q <= state_nx;
            pin_q   <= pin;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ES_LOW:  if (pin_q)  state_nx = ES_HIGH;
            ES_HIGH: if (!pin_q) state_nx = ES_LOW;
        endcase
    end

    always_comb begin
        fall = tick && (state_q == ES_HIGH) && !pin_q;
    end
endmodule

// File: rtl/tmr_chan_core.sv
module tmr_chan_core
    import tmr_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned PRE_W      = 5,
    parameter bit          SPLIT_CAPS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              inc_lo,
    input  logic              inc_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf_lo,
    output logic              ovf_hi
);
    localparam logic [BYTE_W-1:0] B_ONE = {{(BYTE_W-1){1'b0}}, 1'b1};
    localparam logic [PRE_W-1:0]  P_ONE = {{(PRE_W-1){1'b0}}, 1'b1};
    localparam logic [PRE_W-1:0]  P_MAX = {PRE_W{1'b1}};
    localparam logic [BYTE_W-1:0] B_MAX = {BYTE_W{1'b1}};

    logic [BYTE_W-1:0] lo_nx, hi_nx;
    logic              any_wr;

    assign any_wr = wr_lo || wr_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_nx;
            hi <= hi_nx;
        end
    end

    always_comb begin
        lo_nx  = lo;
        hi_nx  = hi;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            MD_13: begin
                if (inc_lo && !any_wr) begin
                    if (lo[PRE_W-1:0] == P_MAX) begin
                        lo_nx[PRE_W-1:0] = '0;
                        hi_nx            = hi + B_ONE;
                        ovf_lo           = (hi == B_MAX);
                    end else begin
                        lo_nx[PRE_W-1:0] = lo[PRE_W-1:0] + P_ONE;
                    end
                end
            end
            MD_16: begin
                if (inc_lo && !any_wr) begin
                    lo_nx = lo + B_ONE;
                    if (lo == B_MAX) begin
                        hi_nx  = hi + B_ONE;
                        ovf_lo = (hi == B_MAX);
                    end
                end
            end
            MD_RELOAD: begin
                if (inc_lo && !any_wr) begin
                    if (lo == B_MAX) begin
                        lo_nx  = hi;
                        ovf_lo = 1'b1;
                    end else begin
                        lo_nx = lo + B_ONE;
                    end
                end
            end
            MD_SPLIT: begin
                if (SPLIT_CAPS) begin
                    if (inc_lo && !wr_lo) begin
                        lo_nx  = lo + B_ONE;
                        ovf_lo = (lo == B_MAX);
                    end
                    if (inc_hi && !wr_hi) begin
                        hi_nx  = hi + B_ONE;
                        ovf_hi = (hi == B_MAX);
                    end
                end
            end
        endcase
        if (wr_lo) lo_nx = wdata;
        if (wr_hi) hi_nx = wdata;
    end
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
    import tmr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PRE_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mc_tick,
    input  logic [NCH-1:0]       cnt_pin,
    input  logic [NCH-1:0]       gate_pin,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata,
    input  logic [NCH-1:0]       intack,
    output logic [NCH-1:0]       irq_flag
);
    localparam int unsigned MODE_W = NCH * CFG_W;

    logic [MODE_W-1:0] mode_q;
    logic [NCH-1:0]    run_q;
    logic [NCH-1:0]    gate_q;
    logic [NCH-1:0]    fall, en, src;
    logic [NCH-1:0]    inc_lo, inc_hi, wr_lo, wr_hi;
    logic [NCH-1:0]    ovf_lo, ovf_hi, flag_set, flag_clr;
    logic [BYTE_W-1:0] lo_b [NCH];
    logic [BYTE_W-1:0] hi_b [NCH];
    chan_cfg_t         cfg  [NCH];
    logic              wr_mode, wr_ctl, split0;

    assign wr_mode = wr_en && (addr == A_MODE);
    assign wr_ctl  = wr_en && (addr == A_CTL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata[MODE_W-1:0];
            if (wr_ctl)  run_q  <= wdata[NCH-1:0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cfg[g]   = chan_cfg_t'(mode_q[CFG_W*g +: CFG_W]);
        assign wr_lo[g] = wr_en && (addr == ADDR_W'(2*g));
        assign wr_hi[g] = wr_en && (addr == ADDR_W'(2*g + 1));

        tmr_edge_fsm u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (mc_tick),
            .pin  (cnt_pin[g]),
            .fall (fall[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)       gate_q[g] <= 1'b0;
            else if (mc_tick) gate_q[g] <= gate_pin[g];
        end

        assign en[g]  = run_q[g] && (!cfg[g].gate || gate_q[g]);
        assign src[g] = cfg[g].ext ? fall[g] : mc_tick;

        tmr_chan_core #(
            .BYTE_W    (BYTE_W),
            .PRE_W     (PRE_W),
            .SPLIT_CAPS(g == 0)
        ) u_core (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (cfg[g].mode),
            .inc_lo(inc_lo[g]),
            .inc_hi(inc_hi[g]),
            .wr_lo (wr_lo[g]),
            .wr_hi (wr_hi[g]),
            .wdata (wdata),
            .lo    (lo_b[g]),
            .hi    (hi_b[g]),
            .ovf_lo(ovf_lo[g]),
            .ovf_hi(ovf_hi[g])
        );

        assign flag_clr[g] = (wr_ctl && wdata[CTL_FLAG_LSB + g]) || intack[g];

        always_ff @(posedge clk) begin
            if (!rst_n)           irq_flag[g] <= 1'b0;
            else if (flag_set[g]) irq_flag[g] <= 1'b1;
            else if (flag_clr[g]) irq_flag[g] <= 1'b0;
        end
    end

    assign split0 = (cfg[0].mode == MD_SPLIT);

    always_comb begin
        inc_lo[0]   = en[0] && src[0];
        inc_hi[0]   = mc_tick && run_q[1];
        inc_lo[1]   = split0 ? mc_tick : (en[1] && src[1]);
        inc_hi[1]   = 1'b0;
        flag_set[0] = ovf_lo[0];
        flag_set[1] = split0 ? ovf_hi[0] : (ovf_lo[1] || ovf_hi[1]);
    end

    always_comb begin
        rdata = '0;
        case (addr)
            3'd0:   rdata = lo_b[0];
            3'd1:   rdata = hi_b[0];
            3'd2:   rdata = lo_b[1];
            3'd3:   rdata = hi_b[1];
            A_MODE: rdata = BYTE_W'(mode_q);
            A_CTL:  begin
                rdata[NCH-1:0]                       = run_q;
                rdata[CTL_FLAG_LSB +: NCH]           = irq_flag;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mc_tick,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic [1:0] intack,
    input logic [1:0] irq_flag,
    input logic [7:0] mode_q,
    input logic [7:0] lo0,
    input logic [7:0] hi0,
    input logic [7:0] lo1,
    input logic [7:0] hi1
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag[0] && !intack[0] && !(wr_en && addr == 3'd5 && wdata[4]) |=> irq_flag[0]); // R11

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag[1]) |-> $past(mc_tick)); // R12

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_tick && !wr_en |=> $stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1)); // R12

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == 3'd0 |=> lo0 == $past(wdata)); // R10

    AST_MODE13_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1:0] == 2'b00 && !(wr_en && addr == 3'd0) |=> lo0[7:5] == $past(lo0[7:5])); // R3

    AST_CH1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[5:4] == 2'b11 && !(wr_en && (addr == 3'd2 || addr == 3'd3)) |=> $stable(lo1) && $stable(hi1)); // R7

    AST_RELOAD_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1:0] == 2'b10 && !(wr_en && addr == 3'd1) |=> $stable(hi0)); // R5
endmodule

bind tmr_dual tmr_dual_chk u_tmr_dual_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mc_tick (mc_tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .intack  (intack),
    .irq_flag(irq_flag),
    .mode_q  (mode_q),
    .lo0     (lo_b[0]),
    .hi0     (hi_b[0]),
    .lo1     (lo_b[1]),
    .hi1     (hi_b[1])
);

// File: tb/tmr_dual_bench.sv
module tmr_dual_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] intack = '0;
    logic [1:0] irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tmr_dual u_tmr_dual (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .intack(intack), .irq_flag(irq_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = 3'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mc_tick = 1'b1;
            @(negedge clk); mc_tick = 1'b0;
        end
    endtask

    task automatic chk_ch(input string req, input int ch, input int elo, input int ehi);
        int v;
        rd(2*ch, v);     chk(req, v, elo);
        rd(2*ch + 1, v); chk(req, v, ehi);
    endtask

    function automatic void step(input int md, inout int lo, inout int hi, inout int ov);
        int v;
        case (md)
            0: if ((lo & 31) == 31) begin
                   lo = lo & 8'hE0;
                   if (hi == 255) ov = 1;
                   hi = (hi + 1) & 255;
               end else lo = lo + 1;
            1: begin
                   v = hi * 256 + lo + 1;
                   if (v == 65536) ov = 1;
                   v = v & 65535;
                   hi = v >> 8; lo = v & 255;
               end
            default: if (lo == 255) begin lo = hi; ov = 1; end else lo = lo + 1;
        endcase
    endfunction

    initial begin
        int v, elo, ehi, eov;
        int starts_lo [5] = '{8'h00, 8'hFE, 8'h3D, 8'hFC, 8'hFF};
        int starts_hi [5] = '{8'h00, 8'hFF, 8'hFF, 8'h10, 8'h7F};
        int ns [3] = '{1, 3, 40};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v); chk("R1 reset reg", v, 0);
        end
        chk("R1 reset flags", int'(irq_flag), 0);

        // R2: mode readback and unmapped address
        wr(4, 8'hA5); rd(4, v); chk("R2 mode readback", v, 8'hA5);
        rd(6, v); chk("R2 unmapped", v, 0);

        // R3 R4 R5 R12: sweep modes, channels, start values, step counts
        for (int ch = 0; ch < 2; ch++)
            for (int md = 0; md < 3; md++)
                for (int s = 0; s < 5; s++)
                    for (int k = 0; k < 3; k++) begin
                        wr(5, 8'h30);
                        wr(4, ch == 0 ? md : ((md << 4) | 1));
                        wr(2*ch, starts_lo[s]);
                        wr(2*ch + 1, starts_hi[s]);
                        wr(5, 1 << ch);
                        tk(ns[k]);
                        wr(5, 0);
                        elo = starts_lo[s]; ehi = starts_hi[s]; eov = 0;
                        for (int i = 0; i < ns[k]; i++) step(md, elo, ehi, eov);
                        chk_ch(md == 0 ? "R3 mode13" : (md == 1 ? "R4 mode16" : "R5 reload"), ch, elo, ehi);
                        chk("R11 sweep flag", int'(irq_flag[ch]), eov);
                        tk(2);
                        chk_ch("R12 run off holds", ch, elo, ehi);
                    end

        // R6 R7: split mode
        wr(5, 8'h30);
        wr(0, 8'hFE); wr(1, 8'hFD); wr(2, 8'hFF); wr(3, 8'hFF);
        wr(4, 8'h13);
        wr(5, 8'h01);
        tk(3);
        chk_ch("R6 split low, high idle", 0, 8'h01, 8'hFD);
        chk_ch("R7 ch1 free-runs", 1, 8'h02, 8'h00);
        chk("R6 R7 flags", int'(irq_flag), 1);
        wr(5, 8'h32);
        tk(4);
        chk_ch("R6 split high counts on run1", 0, 8'h01, 8'h01);
        chk_ch("R7 ch1 free-runs", 1, 8'h06, 8'h00);
        chk("R6 flag1 from high byte", int'(irq_flag), 2);

        // R7: ch1 in split freezes
        wr(5, 8'h30);
        wr(4, 8'h31);
        wr(5, 8'h03);
        tk(5);
        chk_ch("R7 ch1 frozen", 1, 8'h06, 8'h00);
        chk_ch("R4 ch0 counts", 0, 8'h06, 8'h01);

        // R8: external falling edges
        wr(5, 8'h30); wr(4, 8'h05); wr(0, 0); wr(1, 0); wr(5, 8'h01);
        cnt_pin[0] = 1'b1; tk(2);
        chk_ch("R8 high level no count", 0, 0, 0);
        cnt_pin[0] = 1'b0; tk(1);
        chk_ch("R8 one strobe after drop", 0, 0, 0);
        tk(1);
        chk_ch("R8 second strobe after drop", 0, 1, 0);
        for (int i = 0; i < 10; i++) begin
            cnt_pin[0] = 1'b1; tk(1);
            cnt_pin[0] = 1'b0; tk(1);
        end
        tk(2);
        chk_ch("R8 ten pulses", 0, 11, 0);
        tk(4);
        chk_ch("R8 idle pin", 0, 11, 0);

        // R9: gate
        wr(5, 8'h30); wr(4, 8'h09); wr(0, 0); wr(1, 0); wr(5, 8'h01);
        gate_pin[0] = 1'b0; tk(3);
        chk_ch("R9 gate low", 0, 0, 0);
        gate_pin[0] = 1'b1; tk(1);
        chk_ch("R9 gate sample latency", 0, 0, 0);
        tk(3);
        chk_ch("R9 gate high counts", 0, 3, 0);
        gate_pin[0] = 1'b0; tk(1);
        chk_ch("R9 gate fall latency", 0, 4, 0);
        tk(2);
        chk_ch("R9 gate low again", 0, 4, 0);

        // R10: write beats increment
        wr(5, 8'h30); wr(4, 8'h01); wr(0, 8'hFF); wr(1, 8'hFF); wr(5, 8'h01);
        @(negedge clk);
        mc_tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h55;
        @(negedge clk);
        mc_tick = 1'b0; wr_en = 1'b0;
        chk_ch("R10 write priority", 0, 8'h55, 8'hFF);
        chk("R10 no flag", int'(irq_flag[0]), 0);

        // R11: flag clearing
        wr(0, 8'hFF); tk(1);
        chk("R11 flag set", int'(irq_flag[0]), 1);
        wr(5, 8'h01);
        chk("R11 write 0 keeps", int'(irq_flag[0]), 1);
        rd(5, v); chk("R2 ctl readback", v, 8'h11);
        @(negedge clk); intack[0] = 1'b1;
        @(negedge clk); intack[0] = 1'b0;
        chk("R11 intack clears", int'(irq_flag[0]), 0);
        wr(0, 8'hFF); wr(1, 8'hFF); tk(1);
        wr(5, 8'h11);
        chk("R11 w1c clears", int'(irq_flag[0]), 0);
        wr(0, 8'hFF); wr(1, 8'hFF);
        @(negedge clk); mc_tick = 1'b1; intack[0] = 1'b1;
        @(negedge clk); mc_tick = 1'b0; intack[0] = 1'b0;
        chk("R11 set wins", int'(irq_flag[0]), 1);

        done = 1'b1;
        summary();
    end
endmodule